// File: doc/BRIEF.md
# Game Controller Port Reader

This block assembles the two read bytes that a console CPU sees when it polls its controller ports. It takes the live button vectors of two pads, where a 1 means pressed. It also holds a CPU-written port-control byte. That byte sets, for each of the two handshake lines on each pad connector (a "select" line and a "trigger" line), whether the line is an input and what level it drives as an output. Buttons read back active-low: a pressed button reads 0.

There are two readable ports. Port A carries all six low buttons of pad 0 and the first two buttons of pad 1. Port B carries the remaining four pad-1 buttons and two fixed bits. Its top two bits show the handshake lines. When such a line is set to drive, it reads back the level programmed in the control byte. When it is set as an input, it reads 1, because nothing is connected to pull it.

The CPU loads the control byte with a write strobe. A read strobe captures the selected byte into an output register, which then holds steady for the rest of the bus cycle. A parameter can select a purely combinational read path instead.

Top module: `pad_port_reader`

## Requirements
- R1: After reset the control byte is 0xFF (every handshake line an input) and `rd_data` is 0xFF.
- R2: A port A read (`rd_sel`=0) gives bits 4:0 = NOT pad0 buttons 4:0 and bits 7:6 = NOT pad1 buttons 1:0. Bit 5 = NOT pad0 button 5 when control bit 0 is clear.
- R3: On a port A read with control bit 0 set, bit 5 is 0 whatever pad0 button 5 is.
- R4: A port B read (`rd_sel`=1) gives bits 3:0 = NOT pad1 buttons 5:2.
- R5: Port B bits 5:4 always read as 1.
- R6: Port B bit 7 reads 1 when control bit 3 is set (line is an input). Otherwise it equals control bit 7.
- R7: Port B bit 6 reads 1 when control bit 1 is set (line is an input). Otherwise it equals control bit 5.
- R8: A cycle with `wr_stb` high loads `wr_data` into the control byte at that clock edge. A read in the same cycle uses the previous control value.
- R9: `rd_data` takes the selected byte at the clock edge where `rd_stb` is high. It holds its value in every cycle where `rd_stb` is low.
- R10: Pad button bits at index 6 and above never affect either port.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pad0_btn | input | PAD_W | Pad 0 buttons, 1 = pressed |
| pad1_btn | input | PAD_W | Pad 1 buttons, 1 = pressed |
| wr_stb | input | 1 | Load the control byte from `wr_data` |
| wr_data | input | 8 | New control byte |
| rd_stb | input | 1 | Capture the selected port byte |
| rd_sel | input | 1 | 0 = port A, 1 = port B |
| rd_data | output | 8 | Active-low read byte |

## Verification
The assertions assume that strobes and the select are clean, two-valued signals that change only between clock edges. They also assume the pad vectors are stable around the sampling edge. The bench drives every input on the falling edge and holds it across the rising edge, so each strobe lasts exactly one full cycle. Random control bytes are written between reads, so the checks on the handshake lines see every mix of direction and level bits. Directed cases add a write and a read in the same cycle, and idle stretches in which the pads change but no read strobe arrives.

// File: rtl/pad_port_pkg.sv
package pad_port_pkg;
   localparam int BYTE_W = 8;

   typedef enum logic {
      PORT_A = 1'b0,
      PORT_B = 1'b1
   } port_sel_e;

   // control byte field positions (decoded by the read muxes)
   localparam int CTL_A5_CLR = 0;
   localparam int CTL_TR_DIR = 1;
   localparam int CTL_TH_DIR = 3;
   localparam int CTL_TR_LVL = 5;
   localparam int CTL_TH_LVL = 7;

   localparam logic [BYTE_W-1:0] CTL_RESET = 8'hFF;
   localparam logic [BYTE_W-1:0] IDLE_BYTE = 8'hFF;
endpackage

// File: rtl/pad_ctl_reg.sv
module pad_ctl_reg
   import pad_port_pkg::*;
#(
   parameter logic [BYTE_W-1:0] RESET_VAL = CTL_RESET
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_stb,
   input  logic [BYTE_W-1:0] wr_data,
   output logic [BYTE_W-1:0] ctl_q
);
   always_ff @(posedge clk) begin
      if (!rst_n)      ctl_q <= RESET_VAL;
      else if (wr_stb) ctl_q <= wr_data;
   end

   AST_CTL_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
      wr_stb |=> ctl_q == $past(wr_data)); // R8
   AST_CTL_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
      (!wr_stb && $past(rst_n)) |=> $stable(ctl_q)); // R8
endmodule

// File: rtl/pad_port_a_mux.sv
module pad_port_a_mux
   import pad_port_pkg::*;
(
   input  logic [5:0]        p0_btn,
   input  logic [1:0]        p1_btn,
   input  logic              a5_clr,
   output logic [BYTE_W-1:0] byte_a
);
   always_comb begin
      byte_a = ~{p1_btn, p0_btn};
      if (a5_clr) byte_a[5] = 1'b0;
   end

   always_comb begin
      if (a5_clr) assert (byte_a[5] == 1'b0); // R3
   end
endmodule

// File: rtl/pad_port_b_mux.sv
module pad_port_b_mux
   import pad_port_pkg::*;
(
   input  logic [3:0]        p1_hi_btn,
   input  logic [1:0]        line_dir,   // [1] select line, [0] trigger line; 1 = input
   input  logic [1:0]        line_lvl,   // output level for the same lines
   output logic [BYTE_W-1:0] byte_b
);
   logic [1:0] line_rd;

   // a line set as input floats high; a driven line reads its programmed level
   for (genvar g = 0; g < 2; g++) begin : g_line
      assign line_rd[g] = line_dir[g] | line_lvl[g];
   end

   assign byte_b = {line_rd, 2'b11, ~p1_hi_btn};
endmodule

// File: rtl/pad_port_reader.sv
module pad_port_reader
   import pad_port_pkg::*;
#(
   parameter int unsigned       PAD_W     = 8,
   parameter bit                REG_OUT   = 1'b1,
   parameter logic [BYTE_W-1:0] CTL_INIT  = CTL_RESET
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [PAD_W-1:0]  pad0_btn,
   input  logic [PAD_W-1:0]  pad1_btn,
   input  logic              wr_stb,
   input  logic [BYTE_W-1:0] wr_data,
   input  logic              rd_stb,
   input  logic              rd_sel,
   output logic [BYTE_W-1:0] rd_data
);
   if (PAD_W < 6) begin : g_bad_w
      $error("pad_port_reader: PAD_W must be at least 6");
   end

   logic [BYTE_W-1:0] ctl_q;
   logic [BYTE_W-1:0] byte_a;
   logic [BYTE_W-1:0] byte_b;
   logic [BYTE_W-1:0] byte_sel;
   port_sel_e         sel;

   assign sel = port_sel_e'(rd_sel);

   pad_ctl_reg #(.RESET_VAL(CTL_INIT)) u_ctl (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_stb  (wr_stb),
      .wr_data (wr_data),
      .ctl_q   (ctl_q)
   );

   pad_port_a_mux u_a (
      .p0_btn (pad0_btn[5:0]),
      .p1_btn (pad1_btn[1:0]),
      .a5_clr (ctl_q[CTL_A5_CLR]),
      .byte_a (byte_a)
   );

   pad_port_b_mux u_b (
      .p1_hi_btn (pad1_btn[5:2]),
      .line_dir  ({ctl_q[CTL_TH_DIR], ctl_q[CTL_TR_DIR]}),
      .line_lvl  ({ctl_q[CTL_TH_LVL], ctl_q[CTL_TR_LVL]}),
      .byte_b    (byte_b)
   );

   assign byte_sel = (sel == PORT_B) ? byte_b : byte_a;

   // control bits with no read-back role
   logic unused_ctl;
   assign unused_ctl = ^{ctl_q[6], ctl_q[4], ctl_q[2]};

   if (PAD_W > 6) begin : g_wide
      logic unused_pad;
      assign unused_pad = ^{pad0_btn[PAD_W-1:6], pad1_btn[PAD_W-1:6]};
   end

   if (REG_OUT) begin : g_reg
      logic [BYTE_W-1:0] rd_q;
      always_ff @(posedge clk) begin
         if (!rst_n)      rd_q <= IDLE_BYTE;
         else if (rd_stb) rd_q <= byte_sel;
      end
      assign rd_data = rd_q;

      AST_RD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
         (!rd_stb && $past(rst_n)) |=> $stable(rd_data)); // R9
      AST_B_FIXED: assert property (@(posedge clk) disable iff (!rst_n)
         (rd_stb && rd_sel) |=> rd_data[5:4] == 2'b11); // R5
      AST_TH_FLOAT: assert property (@(posedge clk) disable iff (!rst_n)
         (rd_stb && rd_sel && ctl_q[CTL_TH_DIR]) |=> rd_data[7]); // R6
      AST_TR_FLOAT: assert property (@(posedge clk) disable iff (!rst_n)
         (rd_stb && rd_sel && ctl_q[CTL_TR_DIR]) |=> rd_data[6]); // R7
      AST_A5_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
         (rd_stb && !rd_sel && ctl_q[CTL_A5_CLR]) |=> !rd_data[5]); // R3
   end else begin : g_comb
      assign rd_data = byte_sel;
   end
endmodule

// File: tb/tb_pad_port_reader.sv
module tb_pad_port_reader;
   localparam int PAD_W = 8;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic [PAD_W-1:0] pad0_btn = '0;
   logic [PAD_W-1:0] pad1_btn = '0;
   logic             wr_stb = 1'b0;
   logic [7:0]       wr_data = '0;
   logic             rd_stb = 1'b0;
   logic             rd_sel = 1'b0;
   logic [7:0]       rd_data;

   int n_chk = 0;
   int n_bad = 0;
   logic [7:0] ctl_m;

   always #4 clk = ~clk;   // 125 MHz

   pad_port_reader #(.PAD_W(PAD_W)) dut (
      .clk(clk), .rst_n(rst_n), .pad0_btn(pad0_btn), .pad1_btn(pad1_btn),
      .wr_stb(wr_stb), .wr_data(wr_data), .rd_stb(rd_stb), .rd_sel(rd_sel),
      .rd_data(rd_data)
   );

   function automatic logic [7:0] exp_a(logic [7:0] c, logic [PAD_W-1:0] p0, logic [PAD_W-1:0] p1);
      logic [7:0] v;
      v = {~p1[1], ~p1[0], ~p0[5:0]};
      if (c[0]) v[5] = 1'b0;
      return v;
   endfunction

   function automatic logic [7:0] exp_b(logic [7:0] c, logic [PAD_W-1:0] p1);
      logic [7:0] v;
      v[3:0] = ~p1[5:2];
      v[5:4] = 2'b11;
      v[7] = c[3] ? 1'b1 : c[7];
      v[6] = c[1] ? 1'b1 : c[5];
      return v;
   endfunction

   task automatic check(string req, logic [7:0] act, logic [7:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: got %02h expected %02h", req, act, exp);
      end
   endtask

   task automatic wr_ctl(logic [7:0] d);
      @(negedge clk);
      wr_stb = 1'b1; wr_data = d;
      @(negedge clk);
      wr_stb = 1'b0;
      ctl_m = d;
   endtask

   task automatic rd_port(logic s, string req);
      logic [7:0] e;
      @(negedge clk);
      rd_stb = 1'b1; rd_sel = s;
      e = s ? exp_b(ctl_m, pad1_btn) : exp_a(ctl_m, pad0_btn, pad1_btn);
      @(negedge clk);
      rd_stb = 1'b0;
      check(req, rd_data, e);
   endtask

   initial begin : watchdog
      repeat (100000) @(posedge clk);
      n_chk++; n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end

   initial begin : main
      logic [7:0] held;
      void'($urandom(32'h1357_9BDF));
      ctl_m = 8'hFF;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check("R1 idle byte", rd_data, 8'hFF);
      pad1_btn = 8'b0010_1000;
      rd_port(1'b1, "R1 reset ctl via port B");
      pad0_btn = 8'h3F;
      rd_port(1'b0, "R1 reset ctl clears A5");

      // R2 and R3
      wr_ctl(8'h00);
      pad0_btn = 8'b0010_0101; pad1_btn = 8'b0000_0010;
      rd_port(1'b0, "R2 port A pattern");
      wr_ctl(8'h01);
      rd_port(1'b0, "R3 A5 forced low");
      pad0_btn = 8'h00;
      rd_port(1'b0, "R3 A5 forced low, button up");

      // R4..R7 over the four direction/level mixes
      pad1_btn = 8'b0001_0100;
      wr_ctl(8'hA0); rd_port(1'b1, "R6 R7 driven high");
      wr_ctl(8'h00); rd_port(1'b1, "R6 R7 driven low");
      wr_ctl(8'h08); rd_port(1'b1, "R6 select line input");
      wr_ctl(8'h02); rd_port(1'b1, "R7 trigger line input");
      pad1_btn = 8'h3C;
      rd_port(1'b1, "R4 R5 all high buttons");

      // R8: write and read in the same cycle sees old control
      @(negedge clk);
      wr_stb = 1'b1; wr_data = 8'h88; rd_stb = 1'b1; rd_sel = 1'b1;
      held = exp_b(ctl_m, pad1_btn);
      @(negedge clk);
      wr_stb = 1'b0; rd_stb = 1'b0;
      check("R8 same-cycle read uses old ctl", rd_data, held);
      ctl_m = 8'h88;
      rd_port(1'b1, "R8 new ctl visible");

      // R9: hold while no strobe
      held = rd_data;
      for (int i = 0; i < 5; i++) begin
         @(negedge clk);
         pad0_btn = 8'($urandom); pad1_btn = 8'($urandom);
      end
      check("R9 hold without strobe", rd_data, held);

      // R10: high pad bits ignored
      pad0_btn = 8'h15; pad1_btn = 8'h2A;
      rd_port(1'b0, "R10 base A");
      held = rd_data;
      pad0_btn[7:6] = 2'b11; pad1_btn[7:6] = 2'b11;
      rd_port(1'b0, "R10 high bits A");
      check("R10 A unchanged", rd_data, held);
      rd_port(1'b1, "R10 high bits B");

      // random mix
      for (int i = 0; i < 300; i++) begin
         if ($urandom_range(3) == 0) wr_ctl(8'($urandom));
         pad0_btn = 8'($urandom); pad1_btn = 8'($urandom);
         rd_port(1'($urandom), "R2 R3 R4 R5 R6 R7 random");
      end

      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end
endmodule